// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital control core of a serial successive-approximation converter. While chip select is low, the host clocks an 8-bit command into the serial data input on the serial clock. The command names an input channel, picks single-ended or paired differential routing, and picks a unipolar or bipolar output code. The block drives the analog front end with a track/hold control, the positive and negative mux selects, a flag that routes the negative side to the common input, and a flag that swaps the hold node onto the negative input during conversion.

It then runs a 12-step binary search. The trial code goes to the capacitive DAC, and each step keeps or clears one trial bit according to a single comparator bit. The result is shifted out MSB first on the serial data output. A one-SCLK strobe marks the moment the result is ready.

The block runs on a system clock. The serial clock is assumed to be synchronous to that clock, and each of its levels is held for at least two system clock cycles. Edges of the serial clock are found by comparing it with its value one system clock earlier.

Top module: `sar_adc_seq`

## Requirements
- R1: While waiting for a command, rising serial-clock edges with sdi low are ignored. The first rising edge with sdi high is taken as the start bit, which is command bit 7.
- R2: After the start bit, command bits arrive MSB first. Bits 6:4 are the channel, bit 3 set means bipolar, bit 2 set means single-ended, and bits 1:0 are stored without any effect on routing, timing or result.
- R3: th_track rises on the falling serial-clock edge after the fifth command bit and falls on the falling edge after the eighth. It is low at all other times.
- R4: In single-ended mode, mux_pos equals the channel field, neg_to_common is 1 and mux_neg is 0.
- R5: In differential mode, neg_to_common is 0 and the pair is {channel[2:1],0}/{channel[2:1],1}. If channel[0] is 0, mux_pos is the even member and mux_neg the odd member; if channel[0] is 1, they are swapped.
- R6: hold_to_neg rises together with the fall of th_track and stays high until the rising edge that resolves the LSB.
- R7: At the hold edge, dac_code becomes 0x800. Each later rising edge keeps the current trial bit if cmp_in is 1 and clears it if cmp_in is 0. The next lower trial bit is set on the following falling edge. The result is the largest code that does not exceed the comparator input.
- R8: sdo shows the result MSB first, one bit per falling edge. The first bit appears on the falling edge after the LSB is resolved. sdo returns low on the 13th falling edge and is low at all other times.
- R9: In bipolar mode, the MSB of the shifted-out result is inverted (offset binary to two's complement). The other bits are unchanged.
- R10: result_rdy rises after the rising edge that resolves the LSB and falls on the next rising edge.
- R11: cs_n high returns the block to idle on the next clock. th_track, hold_to_neg, sdo and result_rdy go low, and a partly received command is discarded.
- R12: After reset, th_track, hold_to_neg, sdo, result_rdy and dac_code are all zero.
- R13: Once sdo has returned low, a new command can start without cs_n being toggled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, synchronous to clk |
| sdi | input | 1 | Serial command input |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above DAC code |
| th_track | output | 1 | 1 = track, 0 = hold |
| hold_to_neg | output | 1 | Hold node switched to the negative input |
| mux_pos | output | CH_W | Positive input channel |
| mux_neg | output | CH_W | Negative input channel (differential mode) |
| neg_to_common | output | 1 | Negative side tied to the common input |
| dac_code | output | RES_W | Trial code for the capacitive DAC |
| sdo | output | 1 | Serial result output |
| result_rdy | output | 1 | One-SCLK result-ready strobe |

## Verification
The bench places zero bits ahead of the start bit. A design that triggered on any edge would shift every field and route the wrong channel. It uses inputs at full scale and at zero, and differential pairs in which the negative side is larger; an off-by-one in the search would drop or repeat a result bit. It drops chip select during the acquisition window, during the search and during the shift-out, and then checks that a new command converts correctly. A design that kept a partial command or its bit count would convert the wrong channel or hold at the wrong edge. It also starts conversions back to back without releasing chip select, and it repeats commands that differ only in the ignored mode bits or in the polarity bit.

// File: rtl/sar_seq_pkg.sv
// Shared constants for the serial SAR sequencer: command layout and phases.
// Assumes an 8-bit command whose field positions are fixed by the protocol.
package sar_seq_pkg;
    localparam int CTRL_W      = 8;  // command length in bits
    localparam int START_POS   = 7;  // start bit
    localparam int SEL_LO      = 4;  // channel field low bit
    localparam int BIP_POS     = 3;  // 1 = bipolar output code
    localparam int SGL_POS     = 2;  // 1 = single-ended routing
    localparam int TRACK_AFTER = 5;  // track begins after this many bits

    typedef enum logic [1:0] {
        PH_RX   = 2'd0,
        PH_CONV = 2'd1,
        PH_OUT  = 2'd2
    } phase_t;
endpackage

// File: rtl/sar_seq_edge.sv
// Serial clock edge finder. Assumes sclk is synchronous to clk and holds
// each level for at least two clk cycles; no synchronizer is included.
module sar_seq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    // Remember the serial clock level seen one cycle earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/sar_seq_ctrl_rx.sv
// Command receiver: waits for the start bit, places each later bit at its
// final position, and times the track window. Assumes the caller enables
// it only while no conversion or shift-out is in progress.
module sar_seq_ctrl_rx
    import sar_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    output logic [CTRL_W-1:0] word,
    output logic              track,
    output logic              done
);
    localparam int CNT_W = $clog2(CTRL_W + 1);

    logic [CNT_W-1:0] nbits;
    logic             idle_cnt;

    assign idle_cnt = (nbits == '0) || (nbits == CNT_W'(CTRL_W));
    assign done     = en & fall & track & (nbits == CNT_W'(CTRL_W));

    // Collect command bits on rising edges and open/close the track window on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            nbits <= '0;
            word  <= '0;
            track <= 1'b0;
        end else if (en) begin
            if (rise) begin
                if (idle_cnt) begin
                    if (sdi) begin
                        word  <= {1'b1, {(CTRL_W-1){1'b0}}};
                        nbits <= CNT_W'(1);
                    end
                end else begin
                    for (int b = 0; b < CTRL_W - 1; b++) begin
                        if (nbits == CNT_W'(CTRL_W - 1 - b)) word[b] <= sdi;
                    end
                    nbits <= nbits + CNT_W'(1);
                end
            end
            if (fall) begin
                if (nbits == CNT_W'(TRACK_AFTER) && !track) track <= 1'b1;
                else if (done)                             track <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sar_seq_chan_dec.sv
// Channel router: maps the channel field and routing bit onto the front-end
// mux selects. Differential pairs are adjacent channels, with field bit 0
// choosing which member is positive.
module sar_seq_chan_dec #(
    parameter int CH_W = 3
) (
    input  logic [CH_W-1:0] sel,
    input  logic            single,
    output logic [CH_W-1:0] pos,
    output logic [CH_W-1:0] neg,
    output logic            to_common
);
    logic [CH_W-2:0] pair;
    assign pair = sel[CH_W-1:1];

    // Pick the positive/negative channels for the current routing mode.
    always_comb begin
        if (single) begin
            pos       = sel;
            neg       = '0;
            to_common = 1'b1;
        end else begin
            to_common = 1'b0;
            if (sel[0]) begin
                pos = {pair, 1'b1};
                neg = {pair, 1'b0};
            end else begin
                pos = {pair, 1'b0};
                neg = {pair, 1'b1};
            end
        end
    end
endmodule

// File: rtl/sar_seq_sar.sv
// Successive-approximation engine. It loads the MSB trial on start,
// resolves one bit per rising edge from the comparator, and sets the next
// trial bit on the following falling edge. done pulses one clk after the
// LSB is resolved, when the code is final.
module sar_seq_sar #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic             rise,
    input  logic             fall,
    input  logic             cmp,
    output logic [RES_W-1:0] code,
    output logic             busy,
    output logic             done
);
    localparam int IDX_W = $clog2(RES_W);

    logic [IDX_W-1:0] idx;

    // Binary search: trial on falling edges, decision on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            code <= '0;
            idx  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                code <= {1'b1, {(RES_W-1){1'b0}}};
                idx  <= IDX_W'(RES_W - 1);
                busy <= 1'b1;
            end else if (busy) begin
                if (rise) begin
                    code[idx] <= cmp;
                    if (idx == '0) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else if (fall && idx != '0) begin
                    idx             <= idx - IDX_W'(1);
                    code[idx - IDX_W'(1)] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sar_seq_out.sv
// Result serializer and ready strobe. It loads the result on start, raises
// the strobe until the next rising edge, and shifts one bit per falling
// edge MSB first. It drives sdo low again on the falling edge after the last bit.
module sar_seq_out #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic             rise,
    input  logic             fall,
    input  logic [RES_W-1:0] res,
    output logic             sdo,
    output logic             rdy,
    output logic             done
);
    localparam int CNT_W = $clog2(RES_W + 1);

    logic [RES_W-1:0] shreg;
    logic [CNT_W-1:0] sent;
    logic             busy;

    assign done = busy & fall & (sent == CNT_W'(RES_W));

    // Shift the result out and manage the ready strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg <= '0;
            sent  <= '0;
            busy  <= 1'b0;
            sdo   <= 1'b0;
            rdy   <= 1'b0;
        end else if (start) begin
            shreg <= res;
            sent  <= '0;
            busy  <= 1'b1;
            rdy   <= 1'b1;
            sdo   <= 1'b0;
        end else if (busy) begin
            if (rise) rdy <= 1'b0;
            if (fall) begin
                if (sent == CNT_W'(RES_W)) begin
                    sdo  <= 1'b0;
                    busy <= 1'b0;
                end else begin
                    sdo   <= shreg[RES_W-1];
                    shreg <= {shreg[RES_W-2:0], 1'b0};
                    sent  <= sent + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sar_adc_seq.sv
// Top of the serial SAR sequencer. A phase register hands control from the
// command receiver to the search engine to the serializer. Chip select high
// clears every stage. Assumes sclk is synchronous to clk (see sar_seq_edge).
module sar_adc_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic             cmp_in,
    output logic             th_track,
    output logic             hold_to_neg,
    output logic [CH_W-1:0]  mux_pos,
    output logic [CH_W-1:0]  mux_neg,
    output logic             neg_to_common,
    output logic [RES_W-1:0] dac_code,
    output logic             sdo,
    output logic             result_rdy
);
    phase_t            phase;
    logic              s_rise, s_fall;
    logic [CTRL_W-1:0] cmd;
    logic              rx_done, sar_done, out_done;
    logic [RES_W-1:0]  result;

    sar_seq_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk),
        .rise (s_rise),
        .fall (s_fall)
    );

    sar_seq_ctrl_rx u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cs_n),
        .en   (phase == PH_RX),
        .rise (s_rise),
        .fall (s_fall),
        .sdi  (sdi),
        .word (cmd),
        .track(th_track),
        .done (rx_done)
    );

    sar_seq_chan_dec #(.CH_W(CH_W)) u_dec (
        .sel      (cmd[SEL_LO +: CH_W]),
        .single   (cmd[SGL_POS]),
        .pos      (mux_pos),
        .neg      (mux_neg),
        .to_common(neg_to_common)
    );

    sar_seq_sar #(.RES_W(RES_W)) u_sar (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cs_n),
        .start(rx_done),
        .rise (s_rise),
        .fall (s_fall),
        .cmp  (cmp_in),
        .code (dac_code),
        .busy (hold_to_neg),
        .done (sar_done)
    );

    assign result = {dac_code[RES_W-1] ^ cmd[BIP_POS], dac_code[RES_W-2:0]};

    sar_seq_out #(.RES_W(RES_W)) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cs_n),
        .start(sar_done),
        .rise (s_rise),
        .fall (s_fall),
        .res  (result),
        .sdo  (sdo),
        .rdy  (result_rdy),
        .done (out_done)
    );

    // Advance receive -> search -> shift-out -> receive.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            phase <= PH_RX;
        end else begin
            unique case (phase)
                PH_RX:   if (rx_done)  phase <= PH_CONV;
                PH_CONV: if (sar_done) phase <= PH_OUT;
                PH_OUT:  if (out_done) phase <= PH_RX;
                default: phase <= PH_RX;
            endcase
        end
    end
endmodule

// File: rtl/sar_seq_chk.sv
// Assertion checker for sar_adc_seq, attached by bind below. It observes the
// top-level ports only.
module sar_seq_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             th_track,
    input logic             hold_to_neg,
    input logic [RES_W-1:0] dac_code,
    input logic             sdo,
    input logic             result_rdy
);
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    p_track_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        th_track |-> !hold_to_neg);

    p_hold_after_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(th_track) && !cs_n && !$past(cs_n) |-> hold_to_neg);

    p_first_trial_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_to_neg) |-> dac_code == MSB_ONLY);

    p_sdo_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (th_track || hold_to_neg) |-> !sdo);

    p_rdy_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_rdy) |-> !hold_to_neg && !th_track && !sdo);

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !th_track && !hold_to_neg && !sdo && !result_rdy);
endmodule

bind sar_adc_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .th_track   (th_track),
    .hold_to_neg(hold_to_neg),
    .dac_code   (dac_code),
    .sdo        (sdo),
    .result_rdy (result_rdy)
);

// File: tb/tb_sar_adc_seq.sv
module tb_sar_adc_seq;
    localparam int RES_W = 12;
    localparam int CH_W  = 3;
    localparam int HALF  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic cmp_in;
    logic th_track, hold_to_neg, neg_to_common, sdo, result_rdy;
    logic [CH_W-1:0]  mux_pos, mux_neg;
    logic [RES_W-1:0] dac_code;

    logic [11:0] chans [8];
    logic [11:0] com_v;
    logic [11:0] vin_now;
    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sar_adc_seq #(.RES_W(RES_W), .CH_W(CH_W)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .cmp_in(cmp_in), .th_track(th_track), .hold_to_neg(hold_to_neg),
        .mux_pos(mux_pos), .mux_neg(mux_neg), .neg_to_common(neg_to_common),
        .dac_code(dac_code), .sdo(sdo), .result_rdy(result_rdy)
    );

    function automatic logic [11:0] clampd(input logic [11:0] p, input logic [11:0] n);
        return (p > n) ? p - n : 12'd0;
    endfunction

    // Analog front-end and comparator model, driven by the routing ports.
    assign vin_now = clampd(chans[mux_pos], neg_to_common ? com_v : chans[mux_neg]);
    assign cmp_in  = (vin_now >= dac_code);

    function automatic logic [11:0] exp_result(input logic [7:0] w);
        logic [2:0]  s;
        logic [11:0] r;
        s = w[6:4];
        r = clampd(chans[s], w[2] ? com_v : chans[s ^ 3'd1]);
        if (w[3]) r[11] = ~r[11];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hi(input logic b);
        sdi = b; sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic lo();
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    // One full command / search / shift-out sequence with checks.
    task automatic convert(input logic [7:0] w, input int lead0, input bit keep_cs);
        logic [11:0] got, expv;
        logic [2:0]  ep, en;
        int trk_err, quiet_err, hold_err;
        bit ec;
        got = '0; trk_err = 0; quiet_err = 0; hold_err = 0;
        expv = exp_result(w);
        ec = w[2];
        ep = w[6:4];
        en = w[2] ? 3'd0 : (w[6:4] ^ 3'd1);
        if (cs_n) begin
            cs_n = 1'b0;
            repeat (2) @(negedge clk);
        end
        for (int i = 0; i < lead0; i++) begin
            hi(1'b0); lo();
            if (th_track) trk_err++;
        end
        for (int i = 1; i <= 8; i++) begin
            hi(w[8-i]);
            if (sdo) quiet_err++;
            lo();
            if (th_track !== (i >= 5 && i <= 7)) trk_err++;
            if (sdo) quiet_err++;
        end
        chk(trk_err == 0, "R3 track window", trk_err, 0);
        if (lead0 > 0) chk(trk_err == 0, "R1 start bit alignment", trk_err, 0);
        chk(hold_to_neg === 1'b1, "R6 hold swap at hold edge", hold_to_neg, 1);
        chk(dac_code === 12'h800, "R7 first trial", dac_code, 12'h800);
        if (ec) chk({mux_pos, neg_to_common, mux_neg} === {ep, 1'b1, 3'd0},
                    "R4 single-ended routing", {mux_pos, neg_to_common, mux_neg}, {ep, 1'b1, 3'd0});
        else    chk({mux_pos, neg_to_common, mux_neg} === {ep, 1'b0, en},
                    "R5 differential routing", {mux_pos, neg_to_common, mux_neg}, {ep, 1'b0, en});
        for (int j = 1; j <= 12; j++) begin
            hi(1'($urandom));
            if (hold_to_neg !== (j < 12)) hold_err++;
            if (sdo) quiet_err++;
            if (j == 11) chk(result_rdy === 1'b0, "R10 strobe not early", result_rdy, 0);
            if (j == 12) chk(result_rdy === 1'b1, "R10 strobe raised", result_rdy, 1);
            lo();
            if (j < 12 && sdo) quiet_err++;
        end
        chk(hold_err == 0, "R6 hold swap span", hold_err, 0);
        got[11] = sdo;
        for (int k = 1; k <= 11; k++) begin
            hi(1'($urandom));
            if (k == 1) chk(result_rdy === 1'b0, "R10 strobe cleared", result_rdy, 0);
            lo();
            got[11-k] = sdo;
        end
        hi(1'b0); lo();
        if (sdo) quiet_err++;
        chk(quiet_err == 0, "R8 sdo low outside shift-out", quiet_err, 0);
        if (w[3]) chk(got === expv, "R9 bipolar result", got, expv);
        else      chk(got === expv, "R7 search result", got, expv);
        if (!keep_cs) begin
            cs_n = 1'b1;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic idle_check(input string tag);
        chk({th_track, hold_to_neg, sdo, result_rdy} === 4'b0, tag,
            {th_track, hold_to_neg, sdo, result_rdy}, 0);
    endtask

    task automatic rand_chans();
        for (int c = 0; c < 8; c++) begin
            case ($urandom % 4)
                0: chans[c] = 12'd0;
                1: chans[c] = 12'hFFF;
                default: chans[c] = 12'($urandom);
            endcase
        end
        com_v = 12'($urandom % 64);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] w;
        void'($urandom(32'h00C0FFEE));
        for (int c = 0; c < 8; c++) chans[c] = 12'(c * 500 + 7);
        com_v = 12'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R12 reset state
        chk({th_track, hold_to_neg, sdo, result_rdy, dac_code} === '0, "R12 reset state",
            {th_track, hold_to_neg, sdo, result_rdy, dac_code}, 0);

        // Directed: full scale, zero, clamped differential, bipolar, polarity.
        chans[3] = 12'hFFF; com_v = 12'd0;
        convert(8'b1_011_0_1_00, 0, 0);          // R7 full scale single-ended
        chans[3] = 12'd0;
        convert(8'b1_011_0_1_00, 2, 0);          // R7 zero, R1 leading zeros
        chans[4] = 12'd100; chans[5] = 12'd900;
        convert(8'b1_100_0_0_00, 0, 0);          // R5 pos < neg clamps to 0
        convert(8'b1_101_0_0_00, 1, 0);          // R5 swapped polarity
        chans[6] = 12'h123; chans[7] = 12'h020;
        convert(8'b1_110_1_0_00, 0, 0);          // R9 bipolar differential
        convert(8'b1_110_0_0_11, 0, 0);          // R2 mode bits ignored
        convert(8'b1_110_0_0_10, 3, 0);          // R2 mode bits ignored

        // R11 abort during track window, then a clean conversion.
        cs_n = 1'b0; repeat (2) @(negedge clk);
        for (int i = 0; i < 6; i++) begin hi(i == 0 ? 1'b1 : 1'b0); lo(); end
        cs_n = 1'b1; @(negedge clk); @(negedge clk);
        idle_check("R11 abort in acquisition");
        convert(8'b1_010_0_1_01, 0, 0);
        // R11 abort during search.
        cs_n = 1'b0; repeat (2) @(negedge clk);
        for (int i = 0; i < 13; i++) begin hi(i == 0); lo(); end
        cs_n = 1'b1; @(negedge clk); @(negedge clk);
        idle_check("R11 abort in search");
        // R11 abort during shift-out.
        cs_n = 1'b0; repeat (2) @(negedge clk);
        for (int i = 0; i < 24; i++) begin hi(i == 0); lo(); end
        cs_n = 1'b1; @(negedge clk); @(negedge clk);
        idle_check("R11 abort in shift-out");
        convert(8'b1_001_1_1_00, 1, 0);

        // R13 back-to-back without releasing chip select.
        convert(8'b1_000_0_1_00, 0, 1);
        convert(8'b1_111_0_0_00, 0, 1);
        convert(8'b1_010_1_1_11, 1, 0);

        // Random commands and inputs.
        for (int n = 0; n < 40; n++) begin
            rand_chans();
            w = 8'($urandom);
            w[7] = 1'b1;
            convert(w, int'($urandom % 3), bit'($urandom % 4 == 0));
        end
        if (!cs_n) begin cs_n = 1'b1; repeat (2) @(negedge clk); end
        idle_check("R11 idle at end");

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule